// File: doc/BRIEF.md
# Four-Phase Traffic Light Controller

This block drives the lamps at a crossing of two roads, north-south and east-west. A Moore state machine steps through four phases in a fixed loop: north-south green, north-south yellow, east-west green, east-west yellow, then back to the first phase. Each road has its own red, yellow and green output, and the lamps are decoded from the phase alone.

Phase lengths are measured in slow ticks. A divider turns the fast system clock into a one-cycle enable pulse. With the default count of 33,566,667 cycles and a 25.175 MHz clock, that pulse comes at about 0.75 Hz. A mod-5 timer counts these ticks. A green phase ends when the timer wraps, after five ticks. A yellow phase ends on the first tick. The timer is cleared whenever the phase changes. A synchronous reset returns the machine to north-south green and clears both the divider and the timer.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: While reset is high at a clock edge, the block enters north-south green / east-west red, and the divider and the timer are cleared. With the lamp vector written {ns_red, ns_yellow, ns_green, ew_red, ew_yellow, ew_green}, this phase is 6'b001100.
- R2: At every cycle, exactly one lamp is lit on each road.
- R3: North-south green (6'b001100) lasts 5 ticks, which is 5*DIV_COUNT clock edges after it is entered.
- R4: North-south yellow with east-west red (6'b010100) lasts 1 tick, which is DIV_COUNT edges.
- R5: East-west green with north-south red (6'b100001) lasts 5 ticks.
- R6: East-west yellow with north-south red (6'b100010) lasts 1 tick. The block then returns to north-south green, so one full cycle is 12*DIV_COUNT edges.
- R7: Phases change only in the fixed order north-south green, north-south yellow, east-west green, east-west yellow. The two roads are never non-red at the same time.
- R8: A reset taken in the middle of a phase restarts a full north-south green, because the partial divider count and the partial timer count are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ns_red | output | 1 | North-south red lamp |
| ns_yellow | output | 1 | North-south yellow lamp |
| ns_green | output | 1 | North-south green lamp |
| ew_red | output | 1 | East-west red lamp |
| ew_yellow | output | 1 | East-west yellow lamp |
| ew_green | output | 1 | East-west green lamp |

## Verification
The bench builds the block with DIV_COUNT set to 4 and keeps the mod-5 timer at its default. A full four-phase cycle then takes 48 clock edges, so three complete cycles and a mid-phase reset fit in a few hundred cycles. The expected lamp vector is checked on every clock edge, so every phase boundary is checked at its exact edge. The reset is placed inside the east-west green phase, so the check shows that both partial counts are discarded.

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl #(
  parameter int DIV_COUNT = 33566667,
  parameter int TIMER_MOD = 5
) (
  input  logic clk,
  input  logic rst,
  output logic ns_red,
  output logic ns_yellow,
  output logic ns_green,
  output logic ew_red,
  output logic ew_yellow,
  output logic ew_green
);
  localparam int DW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam int TW = (TIMER_MOD > 1) ? $clog2(TIMER_MOD) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_COUNT - 1);
  localparam logic [TW-1:0] TIM_LAST = TW'(TIMER_MOD - 1);

  typedef enum logic [1:0] {
    NS_GO   = 2'd0,
    NS_SLOW = 2'd1,
    EW_GO   = 2'd2,
    EW_SLOW = 2'd3
  } phase_t;

  phase_t          phase;
  logic [DW-1:0]   div_cnt;
  logic [TW-1:0]   timer;
  logic            tick;
  logic            is_green;
  logic            advance;

  assign tick     = (div_cnt == DIV_LAST);
  assign is_green = (phase == NS_GO) || (phase == EW_GO);
  assign advance  = tick && (!is_green || timer == TIM_LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= NS_GO;
      timer <= '0;
    end else if (advance) begin
      phase <= phase_t'(phase + 2'd1);
      timer <= '0;
    end else if (tick) begin
      timer <= timer + 1'b1;
    end
  end

  assign ns_green  = (phase == NS_GO);
  assign ns_yellow = (phase == NS_SLOW);
  assign ns_red    = (phase == EW_GO) || (phase == EW_SLOW);
  assign ew_green  = (phase == EW_GO);
  assign ew_yellow = (phase == EW_SLOW);
  assign ew_red    = (phase == NS_GO) || (phase == NS_SLOW);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (phase == NS_GO && timer == '0 && div_cnt == '0));

  assert_one_lamp_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({ns_red, ns_yellow, ns_green}) == 1 &&
    $countones({ew_red, ew_yellow, ew_green}) == 1);

  assert_green_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (is_green && !(tick && timer == TIM_LAST)) |=> $stable(phase));

  assert_yellow_one_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (!is_green && tick) |=> phase == phase_t'($past(phase) + 2'd1));

  assert_fixed_order_R7: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == phase_t'($past(phase) + 2'd1) && timer == '0));

  assert_never_both_go_R7: assert property (@(posedge clk) disable iff (rst)
    ns_red || ew_red);
endmodule

// File: tb/traffic_phase_ctrl_test.sv
module traffic_phase_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ns_red, ns_yellow, ns_green, ew_red, ew_yellow, ew_green;

  int checks = 0;
  int errors = 0;
  int edges_since_release = 0;
  bit finished = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  localparam logic [5:0] P_NS_GO   = 6'b001100;
  localparam logic [5:0] P_NS_SLOW = 6'b010100;
  localparam logic [5:0] P_EW_GO   = 6'b100001;
  localparam logic [5:0] P_EW_SLOW = 6'b100010;

  traffic_phase_ctrl #(.DIV_COUNT(DIV), .TIMER_MOD(5)) uut (
    .clk(clk), .rst(rst),
    .ns_red(ns_red), .ns_yellow(ns_yellow), .ns_green(ns_green),
    .ew_red(ew_red), .ew_yellow(ew_yellow), .ew_green(ew_green)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] phase_at(int n);
    int p = (n / DIV) % 12;
    if (p < 5)       return P_NS_GO;
    else if (p == 5) return P_NS_SLOW;
    else if (p < 11) return P_EW_GO;
    else             return P_EW_SLOW;
  endfunction

  function automatic string tag_at(int n);
    int p = (n / DIV) % 12;
    if (p < 5)       return "R3";
    else if (p == 5) return "R4";
    else if (p < 11) return "R5";
    else             return "R6";
  endfunction

  task automatic hold_reset(int cycles);
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      exp_q.push_back(P_NS_GO);
      tag_q.push_back("R1");
    end
    @(negedge clk) rst = 1'b0;
    edges_since_release = 0;
  endtask

  task automatic run_cycles(int cycles, string force_tag);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      edges_since_release++;
      exp_q.push_back(phase_at(edges_since_release));
      tag_q.push_back(force_tag == "" ? tag_at(edges_since_release) : force_tag);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [5:0] got;
      logic [5:0] want;
      string      tag;
      got  = {ns_red, ns_yellow, ns_green, ew_red, ew_yellow, ew_green};
      want = exp_q.pop_front();
      tag  = tag_q.pop_front();
      checks++;
      if (got !== want) begin
        errors++;
        $display("FAIL %s lamps got %b expected %b", tag, got, want);
      end
      checks++;
      if ($countones(got[5:3]) != 1 || $countones(got[2:0]) != 1) begin
        errors++;
        $display("FAIL R2 lamps per road got %b expected one-hot per road", got);
      end
      checks++;
      if (!got[5] && !got[2]) begin
        errors++;
        $display("FAIL R7 both roads non-red got %b expected one red", got);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hold_reset(3);
    run_cycles(36 * DIV, "");
    run_cycles(7 * DIV + 2, "");
    hold_reset(2);
    run_cycles(12 * DIV + 3, "R8");
    run_cycles(12 * DIV, "");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule